// File: doc/BRIEF.md
# Segmented Multi-Trigger Capture Buffer

This block records a sample stream into one RAM that is cut into equal regions, each as long as one capture window. While armed, incoming samples are written round-robin inside the active region only, so that region always holds the most recent history. A trigger that arrives with a sample starts a tail count. Once the programmed number of further samples has been stored, that region is closed. Its oldest-sample position is saved, and the next region becomes active. Nothing is copied. Software reads a region and its saved start position and unwraps the window itself.

The number of regions used per run is programmable. After the last one closes, the block reports completion and ignores the stream until a clear returns it to region 0. While disarmed, a read port returns one stored sample, the start position and a short-window flag for any region, one cycle after the request.

Top module: `seg_capture`

## Requirements
- R1: After reset, `cur_seg_o` is 0 and `done_o`, `tail_o` and `rd_valid_o` are 0.
- R2: While armed and not done, each sample with `smp_valid_i` high is written to offset k mod SEG_DEPTH of the active region, where k counts the samples written to that region since it became active. The address of a sample is region*SEG_DEPTH + offset. Other regions are not touched.
- R3: A sample carrying `trig_i` is stored, and exactly `post_len_i` further samples follow it into the region. The region then closes, so with `post_len_i` = 0 it closes on the trigger sample. `tail_o` is high from the cycle after the trigger sample until the region closes.
- R4: On close, the region's start pointer is set to N mod SEG_DEPTH, where N is the number of samples written to the region. That offset holds the oldest kept sample.
- R5: Regions are used in ascending order starting from 0. `cur_seg_o` names the active region.
- R6: A region's short flag is set when N < SEG_DEPTH at close and is cleared otherwise.
- R7: When the region numbered seg_count-1 closes, `done_o` rises and `cur_seg_o` stays put. Further samples and triggers are not stored. `clear_i` returns `cur_seg_o` to 0 and lowers `done_o`.
- R8: A `seg_count_i` of 0, or one above NUM_SEG, uses all NUM_SEG regions.
- R9: `rd_en_i` with `arm_i` low gives `rd_valid_o` = 1 in the next cycle. In that cycle `rd_data_o`, `rd_ptr_o` and `rd_short_o` belong to region `rd_seg_i` at offset `rd_off_i`. With `arm_i` high, `rd_valid_o` is 0 in the next cycle.
- R10: Dropping `arm_i` abandons an open capture. On re-arming, the active region restarts at offset 0 with a sample count of 0.
- R11: `trig_i` has no effect when `smp_valid_i` is low, or when it arrives during a tail count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | Recording enable; read port works only while low |
| clear_i | input | 1 | Return to region 0 and drop done |
| seg_count_i | input | SEG_W+1 | Regions used per run |
| post_len_i | input | OFF_W | Samples stored after the trigger sample |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | DATA_W | Sample value |
| trig_i | input | 1 | Trigger, qualified by the sample strobe |
| rd_en_i | input | 1 | Read request |
| rd_seg_i | input | SEG_W | Region to read |
| rd_off_i | input | OFF_W | Offset inside region |
| rd_valid_o | output | 1 | Read result valid |
| rd_data_o | output | DATA_W | Stored sample |
| rd_ptr_o | output | OFF_W | Saved start pointer of region |
| rd_short_o | output | 1 | Short-window flag of region |
| cur_seg_o | output | SEG_W | Active region |
| done_o | output | 1 | All regions of the run are closed |
| tail_o | output | 1 | Post-trigger count in progress |

## Verification
The bench sends windows whose sample count exceeds, equals and falls short of the region size. It checks every written offset against values computed from the sample's index. A wrap that spilled into the next region, or one that ran over the whole RAM, would show up as wrong data or a wrong pointer. A zero-length tail, a trigger during the tail, and a trigger without a sample strobe each check that the region closes after exactly the right count. A design that retriggered or closed one sample late would shift the pointer. Abandoning a capture by disarming shows whether the offset restarts. A stale offset gives pointer 4 instead of 7. Samples sent after completion, and a region count of 0, check that writing stops at the right region and that the done flag is neither early nor late.

// File: rtl/seg_cap_pkg.sv
package seg_cap_pkg;

    localparam int DEF_DATA_W    = 8;
    localparam int DEF_SEG_DEPTH = 8;
    localparam int DEF_NUM_SEG   = 4;

    // History: filling the region ring; Tail: counting post-trigger samples
    typedef enum logic {
        PH_HISTORY = 1'b0,
        PH_TAIL    = 1'b1
    } phase_e;

    // Last region index of a run; out-of-range counts use every region
    function automatic int unsigned last_region(input int unsigned cnt,
                                                input int unsigned nseg);
        if (cnt == 0 || cnt > nseg)
            return nseg - 1;
        return cnt - 1;
    endfunction

endpackage

// File: rtl/seg_cap_ctrl.sv
module seg_cap_ctrl
    import seg_cap_pkg::*;
#(
    parameter int SEG_DEPTH = DEF_SEG_DEPTH,
    parameter int NUM_SEG   = DEF_NUM_SEG,
    localparam int OFF_W    = $clog2(SEG_DEPTH),
    localparam int SEG_W    = $clog2(NUM_SEG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm_i,
    input  logic             clear_i,
    input  logic             smp_valid_i,
    input  logic             trig_i,
    input  logic [OFF_W-1:0] post_len_i,
    input  logic [SEG_W-1:0] seg_last_i,
    output logic             wr_en_o,
    output logic [OFF_W-1:0] wr_off_o,
    output logic [SEG_W-1:0] cur_seg_o,
    output logic             done_o,
    output logic             tail_o,
    output logic             fin_o,
    output logic [SEG_W-1:0] fin_seg_o,
    output logic [OFF_W-1:0] fin_ptr_o,
    output logic             fin_short_o
);
    localparam int FILL_W = $clog2(SEG_DEPTH + 1);
    localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(SEG_DEPTH);

    phase_e             phase;
    logic [OFF_W-1:0]   off;
    logic [FILL_W-1:0]  fill;
    logic [OFF_W-1:0]   remain;
    logic [SEG_W-1:0]   seg;
    logic               done;

    logic               accept;
    logic [OFF_W-1:0]   off_nx;
    logic [FILL_W-1:0]  fill_nx;
    logic               fin;

    always_comb begin
        accept  = arm_i && !done && smp_valid_i && !clear_i;
        off_nx  = off + OFF_W'(1);
        fill_nx = (fill == FILL_FULL) ? fill : fill + FILL_W'(1);
        fin     = accept &&
                  (((phase == PH_HISTORY) && trig_i && (post_len_i == '0)) ||
                   ((phase == PH_TAIL) && (remain == OFF_W'(1))));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_HISTORY;
            off    <= '0;
            fill   <= '0;
            remain <= '0;
            seg    <= '0;
            done   <= 1'b0;
        end else if (clear_i) begin
            phase  <= PH_HISTORY;
            off    <= '0;
            fill   <= '0;
            remain <= '0;
            seg    <= '0;
            done   <= 1'b0;
        end else if (!arm_i) begin
            phase  <= PH_HISTORY;
            off    <= '0;
            fill   <= '0;
            remain <= '0;
        end else if (accept) begin
            if (fin) begin
                phase  <= PH_HISTORY;
                off    <= '0;
                fill   <= '0;
                remain <= '0;
                if (seg >= seg_last_i)
                    done <= 1'b1;
                else
                    seg <= seg + SEG_W'(1);
            end else begin
                off  <= off_nx;
                fill <= fill_nx;
                if (phase == PH_HISTORY && trig_i) begin
                    phase  <= PH_TAIL;
                    remain <= post_len_i;
                end else if (phase == PH_TAIL) begin
                    remain <= remain - OFF_W'(1);
                end
            end
        end
    end

    assign wr_en_o     = accept;
    assign wr_off_o    = off;
    assign cur_seg_o   = seg;
    assign done_o      = done;
    assign tail_o      = (phase == PH_TAIL);
    assign fin_o       = fin;
    assign fin_seg_o   = seg;
    assign fin_ptr_o   = off_nx;
    assign fin_short_o = (fill_nx < FILL_FULL);

    // R6: the sample count never passes the region size
    a_r6_fill_bound: assert property (@(posedge clk) disable iff (rst)
        fill <= FILL_FULL);

    // R3: a tail in progress always has samples left to take
    a_r3_tail_nonzero: assert property (@(posedge clk) disable iff (rst)
        phase == PH_TAIL |-> remain != '0);

    // R5: closing a non-final region steps to the next one
    a_r5_seg_step: assert property (@(posedge clk) disable iff (rst)
        fin && !clear_i && (seg < seg_last_i) |=> seg == $past(seg) + SEG_W'(1));

    // R7: closing the final region raises done
    a_r7_done_at_last: assert property (@(posedge clk) disable iff (rst)
        fin && !clear_i && (seg >= seg_last_i) |=> done);

    // R7: once done, the region index holds until a clear
    a_r7_done_holds: assert property (@(posedge clk) disable iff (rst)
        done && !clear_i |=> $stable(seg) && done);

endmodule

// File: rtl/seg_cap_mem.sv
module seg_cap_mem #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              re_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] ram [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i)
            ram[waddr_i] <= wdata_i;
        if (re_i)
            rdata_o <= ram[raddr_i];
    end
endmodule

// File: rtl/seg_cap_ptr_tab.sv
module seg_cap_ptr_tab #(
    parameter int SEG_DEPTH = 8,
    parameter int NUM_SEG   = 4,
    localparam int OFF_W    = $clog2(SEG_DEPTH),
    localparam int SEG_W    = $clog2(NUM_SEG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic [SEG_W-1:0] wr_seg_i,
    input  logic [OFF_W-1:0] wr_ptr_i,
    input  logic             wr_short_i,
    input  logic             rd_i,
    input  logic [SEG_W-1:0] rd_seg_i,
    output logic [OFF_W-1:0] rd_ptr_o,
    output logic             rd_short_o
);
    logic [OFF_W-1:0] ent_ptr   [NUM_SEG];
    logic             ent_short [NUM_SEG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SEG; i++) begin
                ent_ptr[i]   <= '0;
                ent_short[i] <= 1'b0;
            end
            rd_ptr_o   <= '0;
            rd_short_o <= 1'b0;
        end else begin
            for (int i = 0; i < NUM_SEG; i++) begin
                if (wr_i && wr_seg_i == SEG_W'(i)) begin
                    ent_ptr[i]   <= wr_ptr_i;
                    ent_short[i] <= wr_short_i;
                end
            end
            if (rd_i) begin
                rd_ptr_o   <= ent_ptr[rd_seg_i];
                rd_short_o <= ent_short[rd_seg_i];
            end
        end
    end
endmodule

// File: rtl/seg_capture.sv
module seg_capture
    import seg_cap_pkg::*;
#(
    parameter int DATA_W    = DEF_DATA_W,
    parameter int SEG_DEPTH = DEF_SEG_DEPTH,
    parameter int NUM_SEG   = DEF_NUM_SEG,
    localparam int OFF_W    = $clog2(SEG_DEPTH),
    localparam int SEG_W    = $clog2(NUM_SEG),
    localparam int ADDR_W   = OFF_W + SEG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm_i,
    input  logic              clear_i,
    input  logic [SEG_W:0]    seg_count_i,
    input  logic [OFF_W-1:0]  post_len_i,
    input  logic              smp_valid_i,
    input  logic [DATA_W-1:0] smp_data_i,
    input  logic              trig_i,
    input  logic              rd_en_i,
    input  logic [SEG_W-1:0]  rd_seg_i,
    input  logic [OFF_W-1:0]  rd_off_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [OFF_W-1:0]  rd_ptr_o,
    output logic              rd_short_o,
    output logic [SEG_W-1:0]  cur_seg_o,
    output logic              done_o,
    output logic              tail_o
);
    logic [SEG_W-1:0] seg_last;
    logic             wr_en;
    logic [OFF_W-1:0] wr_off;
    logic             fin;
    logic [SEG_W-1:0] fin_seg;
    logic [OFF_W-1:0] fin_ptr;
    logic             fin_short;
    logic             rd_go;

    assign seg_last = SEG_W'(last_region(32'(seg_count_i), NUM_SEG));
    assign rd_go    = rd_en_i && !arm_i;

    seg_cap_ctrl #(.SEG_DEPTH(SEG_DEPTH), .NUM_SEG(NUM_SEG)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .arm_i       (arm_i),
        .clear_i     (clear_i),
        .smp_valid_i (smp_valid_i),
        .trig_i      (trig_i),
        .post_len_i  (post_len_i),
        .seg_last_i  (seg_last),
        .wr_en_o     (wr_en),
        .wr_off_o    (wr_off),
        .cur_seg_o   (cur_seg_o),
        .done_o      (done_o),
        .tail_o      (tail_o),
        .fin_o       (fin),
        .fin_seg_o   (fin_seg),
        .fin_ptr_o   (fin_ptr),
        .fin_short_o (fin_short)
    );

    seg_cap_mem #(.DATA_W(DATA_W), .DEPTH(SEG_DEPTH * NUM_SEG)) u_mem (
        .clk     (clk),
        .we_i    (wr_en),
        .waddr_i ({cur_seg_o, wr_off}),
        .wdata_i (smp_data_i),
        .re_i    (rd_go),
        .raddr_i ({rd_seg_i, rd_off_i}),
        .rdata_o (rd_data_o)
    );

    seg_cap_ptr_tab #(.SEG_DEPTH(SEG_DEPTH), .NUM_SEG(NUM_SEG)) u_tab (
        .clk        (clk),
        .rst        (rst),
        .wr_i       (fin),
        .wr_seg_i   (fin_seg),
        .wr_ptr_i   (fin_ptr),
        .wr_short_i (fin_short),
        .rd_i       (rd_go),
        .rd_seg_i   (rd_seg_i),
        .rd_ptr_o   (rd_ptr_o),
        .rd_short_o (rd_short_o)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rd_valid_o <= 1'b0;
        else
            rd_valid_o <= rd_go;
    end

    // R9: a disarmed request answers one cycle later
    a_r9_read_latency: assert property (@(posedge clk) disable iff (rst)
        rd_en_i && !arm_i |=> rd_valid_o);

    // R9: no read result while armed
    a_r9_no_read_armed: assert property (@(posedge clk) disable iff (rst)
        arm_i |=> !rd_valid_o);

    // R7: a finished run neither writes nor counts a tail
    a_r7_quiet_when_done: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !wr_en && !tail_o);

    // R8: the active region never passes the last region of the run
    a_r8_seg_in_run: assert property (@(posedge clk) disable iff (rst)
        $stable(seg_count_i) && !clear_i && cur_seg_o <= seg_last |=> cur_seg_o <= seg_last);

endmodule

// File: tb/seg_capture_bench.sv
module seg_capture_bench;
    localparam int DATA_W = 8;
    localparam int SD     = 8;
    localparam int NS     = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       arm_i = 1'b0;
    logic       clear_i = 1'b0;
    logic [2:0] seg_count_i = 3'd3;
    logic [2:0] post_len_i = '0;
    logic       smp_valid_i = 1'b0;
    logic [7:0] smp_data_i = '0;
    logic       trig_i = 1'b0;
    logic       rd_en_i = 1'b0;
    logic [1:0] rd_seg_i = '0;
    logic [2:0] rd_off_i = '0;
    logic       rd_valid_o;
    logic [7:0] rd_data_o;
    logic [2:0] rd_ptr_o;
    logic       rd_short_o;
    logic [1:0] cur_seg_o;
    logic       done_o;
    logic       tail_o;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    seg_capture #(.DATA_W(DATA_W), .SEG_DEPTH(SD), .NUM_SEG(NS)) u_seg_capture (
        .clk(clk), .rst(rst), .arm_i(arm_i), .clear_i(clear_i),
        .seg_count_i(seg_count_i), .post_len_i(post_len_i),
        .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i), .trig_i(trig_i),
        .rd_en_i(rd_en_i), .rd_seg_i(rd_seg_i), .rd_off_i(rd_off_i),
        .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .rd_ptr_o(rd_ptr_o),
        .rd_short_o(rd_short_o), .cur_seg_o(cur_seg_o), .done_o(done_o),
        .tail_o(tail_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // npre samples, the last carrying the trigger, then post samples.
    // Sample k has value base+k.
    task automatic capture(input int npre, input int post, input int base,
                           input bit idle_trig, input bit tail_trig);
        int n = npre + post;
        post_len_i = 3'(post);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (post > 0 && k == npre)
                check(tail_o == 1'b1, "R3 tail after trigger", int'(tail_o), 1);
            if (idle_trig && k == 2) begin
                smp_valid_i = 1'b0;
                trig_i = 1'b1;
                @(negedge clk);
            end
            smp_valid_i = 1'b1;
            smp_data_i  = 8'(base + k);
            trig_i      = (k == npre - 1) || (tail_trig && k == npre + 1);
        end
        @(negedge clk);
        smp_valid_i = 1'b0;
        trig_i = 1'b0;
        check(tail_o == 1'b0, "R3 tail ends at close", int'(tail_o), 0);
    endtask

    // Read every written offset of a region and its pointer and flag
    task automatic read_region(input int seg, input int n, input int base, input string req);
        for (int o = 0; o < SD; o++) begin
            @(negedge clk);
            rd_en_i  = 1'b1;
            rd_seg_i = 2'(seg);
            rd_off_i = 3'(o);
            @(negedge clk);
            rd_en_i = 1'b0;
            check(rd_valid_o == 1'b1, "R9 read valid", int'(rd_valid_o), 1);
            if (o < n) begin
                int k = o + SD * ((n - 1 - o) / SD);
                check(rd_data_o == 8'(base + k), req, int'(rd_data_o), (base + k) & 255);
            end
            if (o == 0) begin
                check(rd_ptr_o == 3'(n % SD), "R4 start pointer", int'(rd_ptr_o), n % SD);
                check(rd_short_o == (n < SD), "R6 short flag", int'(rd_short_o), int'(n < SD));
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cur_seg_o == 2'd0, "R1 reset region", int'(cur_seg_o), 0);
        check(done_o == 1'b0, "R1 reset done", int'(done_o), 0);
        check(tail_o == 1'b0, "R1 reset tail", int'(tail_o), 0);
        check(rd_valid_o == 1'b0, "R1 reset valid", int'(rd_valid_o), 0);

        // run of 3 regions
        seg_count_i = 3'd3;
        arm_i = 1'b1;
        capture(14, 5, 8'h10, 1'b1, 1'b1);   // N=19, ptr 3; R11 idle and tail triggers
        check(cur_seg_o == 2'd1, "R5 next region", int'(cur_seg_o), 1);
        capture(3, 2, 8'h40, 1'b0, 1'b0);    // N=5, short
        check(cur_seg_o == 2'd2, "R5 next region", int'(cur_seg_o), 2);
        check(done_o == 1'b0, "R7 not yet done", int'(done_o), 0);
        capture(8, 0, 8'h80, 1'b0, 1'b0);    // zero tail, N=8
        check(done_o == 1'b1, "R7 done after last", int'(done_o), 1);
        check(cur_seg_o == 2'd2, "R7 region holds", int'(cur_seg_o), 2);

        // stream after completion must not be stored
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            smp_valid_i = 1'b1;
            smp_data_i  = 8'hEE;
            trig_i      = k[0];
        end
        @(negedge clk);
        smp_valid_i = 1'b0;
        trig_i = 1'b0;
        check(cur_seg_o == 2'd2 && done_o, "R7 ignored after done", int'(cur_seg_o), 2);

        // read while armed gives nothing
        rd_en_i = 1'b1;
        @(negedge clk);
        rd_en_i = 1'b0;
        check(rd_valid_o == 1'b0, "R9 armed read blocked", int'(rd_valid_o), 0);

        arm_i = 1'b0;
        read_region(0, 19, 8'h10, "R2 R11 region0 data");
        read_region(1, 5, 8'h40, "R2 region1 data");
        read_region(2, 8, 8'h80, "R7 R3 region2 data");

        // clear, all regions, abandoned capture
        @(negedge clk);
        clear_i = 1'b1;
        @(negedge clk);
        clear_i = 1'b0;
        check(cur_seg_o == 2'd0, "R7 clear region", int'(cur_seg_o), 0);
        check(done_o == 1'b0, "R7 clear done", int'(done_o), 0);
        seg_count_i = 3'd0;
        arm_i = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            smp_valid_i = 1'b1;
            smp_data_i  = 8'(8'h50 + k);
        end
        @(negedge clk);
        smp_valid_i = 1'b0;
        arm_i = 1'b0;
        @(negedge clk);
        arm_i = 1'b1;
        capture(6, 1, 8'h60, 1'b0, 1'b0);    // N=7 after restart
        capture(5, 3, 8'h70, 1'b0, 1'b0);
        capture(5, 3, 8'h90, 1'b0, 1'b0);
        check(done_o == 1'b0, "R8 count 0 uses all regions", int'(done_o), 0);
        check(cur_seg_o == 2'd3, "R8 fourth region active", int'(cur_seg_o), 3);
        capture(4, 4, 8'hB0, 1'b0, 1'b0);
        check(done_o == 1'b1, "R8 done after fourth", int'(done_o), 1);
        arm_i = 1'b0;
        read_region(0, 7, 8'h60, "R10 restart data");
        read_region(3, 8, 8'hB0, "R8 region3 data");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule